// File: doc/BRIEF.md
# DMA Request Priority Arbiter

This block decides which of five requesters is handed the next transfer slot of a DMA engine. Source 0 is a bridge requester; sources 1 to 4 are four external request lines, line 0 to line 3. Every cycle the block looks at the eligible requests and raises at most one bit of a registered one-hot grant in the next cycle. A 2-bit mode register picks the order. Two modes use a fixed order, which differ only in whether the bridge or line 0 comes first. One mode rotates the order. One mode uses the bridge-first order and adds a lockout: after the bridge has been accepted, a line request is refused unless its requester is marked as belonging to the exempt class. The lockout lasts until software clears the bridge acceptance flag.

Three sticky acceptance flags record that the bridge, line 0 or line 1 has been granted. Software clears them with a write-one-to-clear port. Two acknowledge pins belong to lines 2 and 3. For each pin a select bit picks one of two styles. The request-acknowledge style pulses the pin with the grant. The transfer-acknowledge style follows the engine's transfer strobe while that line owns the engine. A status word returns the mode, the two select bits and the three flags.

Top module: `dma_req_arbiter`

## Requirements
- R1: After reset the following are all 0: grant, acknowledge pins, flags, mode and both select bits. status_o therefore reads 0.
- R2: grant_o has at most one bit set. A bit i is set in the cycle after source i had an eligible request. With no eligible request, grant_o is 0. Bit 0 is the bridge and bit i+1 is line i.
- R3: In mode 0 (2'b00) the order is bridge, then line 0, line 1, line 2, line 3.
- R4: In mode 2 (2'b10) the order is line 0, then bridge, line 1, line 2, line 3.
- R5: In mode 3 (2'b11) the order rotates. After reset the bridge is first. After each grant in this mode, the source just granted drops to last and the next source in the cyclic order bridge, line 0 to line 3 becomes first.
- R6: In mode 1 (2'b01) the order is that of mode 0. While the bridge flag is 1, a line request is granted only if its line_exempt_i bit is 1. The bridge itself stays eligible.
- R7: The mode 1 lockout ends in the cycle after the clear write that drops the bridge flag. A blocked line request that is still present is then granted.
- R8: status_o[0] is the flag of the bridge, status_o[1] that of line 0 and status_o[2] that of line 1. A flag becomes 1 at the edge that raises its grant. It stays 1 until a clear write with that bit set in clr_mask_i. If a grant and a clear land in the same cycle, the grant wins.
- R9: Acknowledge pin k serves line k+2. With select bit k at 0, the pin is high in the same cycle as that line's grant. With select bit k at 1, the pin is high in the cycle after a cycle in which xfer_strobe_i was 1 and line k+2 was the most recently granted source.
- R10: A configuration write loads the mode and the select bits at the next edge. status_o[4:3] holds the select bits, status_o[6:5] the mode, and status_o[7] always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_bridge_i | input | 1 | Bridge transfer request |
| req_line_i | input | 4 | External request lines 0..3 |
| line_exempt_i | input | 4 | Line request comes from the exempt class |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_mode_i | input | 2 | Priority mode to load |
| cfg_ack_sel_i | input | 2 | Acknowledge style select bits to load |
| clr_we_i | input | 1 | Flag clear strobe |
| clr_mask_i | input | 3 | Flags to clear, one bit each |
| xfer_strobe_i | input | 1 | Engine data-transfer strobe for the current owner |
| grant_o | output | 5 | Registered one-hot grant |
| ack_o | output | 2 | Acknowledge pins for lines 2 and 3 |
| status_o | output | 8 | Flags, select bits, mode, reserved zero |

## Verification
The assertions assume that requests and configuration are sampled as synchronous levels. They also assume that line_exempt_i is meaningful only where the matching request bit is high, and that a request held over several cycles may be granted again. The stimulus changes every input only on the falling edge, one step per cycle. Each step states all inputs in full, so no value is left over from an earlier step. Lockout stimulus mixes exempt and non-exempt lines in the same cycle. The flag clear is issued while blocked requests are still held, so that both the start and the end of the lockout are observed at the grant output.

// File: rtl/dmarb_pkg.sv
package dmarb_pkg;
  typedef enum logic [1:0] {
    MODE_FIXED  = 2'b00,
    MODE_LOCK   = 2'b01,
    MODE_SWAP   = 2'b10,
    MODE_ROTATE = 2'b11
  } arb_mode_e;
endpackage

// File: rtl/dmarb_picker.sv
module dmarb_picker #(
  parameter int N = 5,
  localparam int W = $clog2(N)
) (
  input  logic [N-1:0] req,
  input  logic [W-1:0] start,
  output logic [N-1:0] gnt,
  output logic [W-1:0] idx,
  output logic         valid
);
  always_comb begin
    gnt   = '0;
    idx   = '0;
    valid = 1'b0;
    for (int i = 0; i < N; i++) begin
      int k;
      k = int'(start) + i;
      if (k >= N) k = k - N;
      if (!valid && req[k]) begin
        valid  = 1'b1;
        gnt[k] = 1'b1;
        idx    = k[W-1:0];
      end
    end
  end
endmodule

// File: rtl/dmarb_regs.sv
module dmarb_regs
  import dmarb_pkg::*;
#(
  parameter int N_FLAG = 3,
  parameter int N_ACK  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_mode,
  input  logic [N_ACK-1:0]  cfg_sel,
  input  logic              clr_we,
  input  logic [N_FLAG-1:0] clr_mask,
  input  logic [N_FLAG-1:0] set_vec,
  output arb_mode_e         mode_q,
  output logic [N_ACK-1:0]  sel_q,
  output logic [N_FLAG-1:0] flag_q
);
  logic [N_FLAG-1:0] clr_eff;
  assign clr_eff = clr_we ? clr_mask : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_FIXED;
      sel_q  <= '0;
      flag_q <= '0;
    end else begin
      if (cfg_we) begin
        mode_q <= arb_mode_e'(cfg_mode);
        sel_q  <= cfg_sel;
      end
      flag_q <= (flag_q & ~clr_eff) | set_vec;
    end
  end

  // R8: a clear without a simultaneous set drops the bridge flag
  a_r8_clear_drops: assert property (@(posedge clk) disable iff (rst)
    (clr_we && clr_mask[0] && !set_vec[0]) |=> !flag_q[0]);
  // R8: a set always wins
  a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
    set_vec[0] |=> flag_q[0]);
endmodule

// File: rtl/dmarb_ack.sv
module dmarb_ack #(
  parameter int N_SRC    = 5,
  parameter int N_ACK    = 2,
  parameter int ACK_BASE = 3,
  localparam int W = $clog2(N_SRC)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] nxt_gnt,
  input  logic             nxt_valid,
  input  logic [W-1:0]     nxt_idx,
  input  logic [N_ACK-1:0] sel_q,
  input  logic             xfer,
  output logic [N_ACK-1:0] ack_o
);
  logic [W-1:0] owner_q;
  logic         owner_v;

  always_ff @(posedge clk) begin
    if (rst) begin
      owner_q <= '0;
      owner_v <= 1'b0;
    end else if (nxt_valid) begin
      owner_q <= nxt_idx;
      owner_v <= 1'b1;
    end
  end

  for (genvar k = 0; k < N_ACK; k++) begin : g_pin
    always_ff @(posedge clk) begin
      if (rst) ack_o[k] <= 1'b0;
      else if (sel_q[k]) ack_o[k] <= xfer && owner_v && (owner_q == W'(ACK_BASE + k));
      else ack_o[k] <= nxt_gnt[ACK_BASE + k];
    end
  end

  // R9: request-acknowledge style follows the grant of its line
  a_r9_req_style: assert property (@(posedge clk) disable iff (rst)
    (!sel_q[0] && nxt_gnt[ACK_BASE]) |=> ack_o[0]);
endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter
  import dmarb_pkg::*;
#(
  parameter int N_LINE   = 4,
  parameter int N_FLAG   = 3,
  parameter int N_ACK    = 2,
  parameter int ACK_BASE = 3,
  localparam int N_SRC   = N_LINE + 1,
  localparam int W       = $clog2(N_SRC),
  localparam int STAT_W  = N_FLAG + N_ACK + 2 + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_bridge_i,
  input  logic [N_LINE-1:0] req_line_i,
  input  logic [N_LINE-1:0] line_exempt_i,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_mode_i,
  input  logic [N_ACK-1:0]  cfg_ack_sel_i,
  input  logic              clr_we_i,
  input  logic [N_FLAG-1:0] clr_mask_i,
  input  logic              xfer_strobe_i,
  output logic [N_SRC-1:0]  grant_o,
  output logic [N_ACK-1:0]  ack_o,
  output logic [STAT_W-1:0] status_o
);
  arb_mode_e         mode_q;
  logic [N_ACK-1:0]  sel_q;
  logic [N_FLAG-1:0] flag_q;
  logic [W-1:0]      ptr_q;
  logic              lock;
  logic              swap;
  logic [N_SRC-1:0]  elig, perm, pick_gnt, nxt_gnt;
  logic [W-1:0]      pick_idx, nxt_idx, start;
  logic              pick_valid;

  assign lock = (mode_q == MODE_LOCK) && flag_q[0];
  assign swap = (mode_q == MODE_SWAP);

  // eligibility: bridge never blocked; lines blocked during lockout unless exempt
  always_comb begin
    elig[0] = req_bridge_i;
    for (int i = 0; i < N_LINE; i++)
      elig[i+1] = req_line_i[i] && !(lock && !line_exempt_i[i]);
  end

  always_comb begin
    perm = elig;
    if (swap) begin
      perm[0] = elig[1];
      perm[1] = elig[0];
    end
  end

  assign start = (mode_q == MODE_ROTATE) ? ptr_q : '0;

  dmarb_picker #(.N(N_SRC)) u_pick (
    .req(perm), .start(start), .gnt(pick_gnt), .idx(pick_idx), .valid(pick_valid)
  );

  always_comb begin
    nxt_gnt = pick_gnt;
    nxt_idx = pick_idx;
    if (swap) begin
      nxt_gnt[0] = pick_gnt[1];
      nxt_gnt[1] = pick_gnt[0];
      if (pick_idx == W'(0)) nxt_idx = W'(1);
      else if (pick_idx == W'(1)) nxt_idx = W'(0);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_o <= '0;
      ptr_q   <= '0;
    end else begin
      grant_o <= nxt_gnt;
      if (mode_q == MODE_ROTATE && pick_valid)
        ptr_q <= (nxt_idx == W'(N_SRC - 1)) ? '0 : nxt_idx + W'(1);
    end
  end

  dmarb_regs #(.N_FLAG(N_FLAG), .N_ACK(N_ACK)) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we_i), .cfg_mode(cfg_mode_i),
    .cfg_sel(cfg_ack_sel_i), .clr_we(clr_we_i), .clr_mask(clr_mask_i),
    .set_vec(nxt_gnt[N_FLAG-1:0]), .mode_q(mode_q), .sel_q(sel_q), .flag_q(flag_q)
  );

  dmarb_ack #(.N_SRC(N_SRC), .N_ACK(N_ACK), .ACK_BASE(ACK_BASE)) u_ack (
    .clk(clk), .rst(rst), .nxt_gnt(nxt_gnt), .nxt_valid(pick_valid),
    .nxt_idx(nxt_idx), .sel_q(sel_q), .xfer(xfer_strobe_i), .ack_o(ack_o)
  );

  assign status_o = {1'b0, mode_q, sel_q, flag_q};

  // R2: never more than one grant
  a_r2_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant_o));
  // R2: a grant needs a request in the previous cycle
  a_r2_needs_req: assert property (@(posedge clk) disable iff (rst)
    (grant_o & ~$past({req_line_i, req_bridge_i})) == '0);
  // R3: bridge wins in the fixed order
  a_r3_bridge_first: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_FIXED && req_bridge_i) |=> grant_o[0]);
  // R4: line 0 wins in the swapped order
  a_r4_line0_first: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_SWAP && req_line_i[0]) |=> grant_o[1]);
  // R6: during lockout only exempt lines are granted
  a_r6_lockout: assert property (@(posedge clk) disable iff (rst)
    lock |=> ((grant_o[N_SRC-1:1] & ~$past(line_exempt_i)) == '0));
endmodule

// File: tb/dma_req_arbiter_tb.sv
module dma_req_arbiter_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_bridge_i = 1'b0;
  logic [3:0] req_line_i = '0, line_exempt_i = '0;
  logic cfg_we_i = 1'b0, clr_we_i = 1'b0, xfer_strobe_i = 1'b0;
  logic [1:0] cfg_mode_i = '0, cfg_ack_sel_i = '0;
  logic [2:0] clr_mask_i = '0;
  logic [4:0] grant_o;
  logic [1:0] ack_o;
  logic [7:0] status_o;

  always #10 clk = ~clk;

  dma_req_arbiter dut_i (.*);

  typedef struct {
    logic [4:0] g;
    logic [1:0] a;
    logic [7:0] s;
    string      tag;
  } exp_t;
  exp_t sb[$];

  int total = 0, bad = 0;
  logic done = 1'b0;

  // bench model state
  int m_mode = 0, m_ptr = 0, m_own = 0;
  logic [1:0] m_sel = '0;
  logic [2:0] m_flag = '0;
  logic m_ownv = 1'b0;

  task automatic step(input string tag, input logic br, input logic [3:0] ln,
                      input logic [3:0] ex, input logic cw, input logic [1:0] md,
                      input logic [1:0] sl, input logic cl, input logic [2:0] mk,
                      input logic xf);
    logic [4:0] el;
    logic [4:0] eg;
    logic [1:0] ea;
    int g;
    logic lk;
    exp_t it;
    @(negedge clk);
    req_bridge_i = br; req_line_i = ln; line_exempt_i = ex;
    cfg_we_i = cw; cfg_mode_i = md; cfg_ack_sel_i = sl;
    clr_we_i = cl; clr_mask_i = mk; xfer_strobe_i = xf;
    lk = (m_mode == 1) && m_flag[0];
    el[0] = br;
    for (int i = 0; i < 4; i++) el[i+1] = ln[i] && !(lk && !ex[i]);
    g = -1;
    for (int p = 0; p < 5; p++) begin
      int s;
      if (m_mode == 2) s = (p == 0) ? 1 : (p == 1) ? 0 : p;
      else if (m_mode == 3) s = (m_ptr + p) % 5;
      else s = p;
      if (g < 0 && el[s]) g = s;
    end
    eg = '0;
    if (g >= 0) eg[g] = 1'b1;
    for (int k = 0; k < 2; k++)
      ea[k] = m_sel[k] ? (xf && m_ownv && m_own == 3 + k) : eg[3+k];
    if (g >= 0 && m_mode == 3) m_ptr = (g + 1) % 5;
    if (g >= 0) begin m_own = g; m_ownv = 1'b1; end
    m_flag = (m_flag & ~(cl ? mk : 3'b000)) | eg[2:0];
    if (cw) begin m_mode = int'(md); m_sel = sl; end
    it.g = eg; it.a = ea;
    it.s = {1'b0, 2'(m_mode), m_sel, m_flag};
    it.tag = tag;
    sb.push_back(it);
  endtask

  // monitor: pops one expectation per clock, 2 ns after the edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        exp_t it;
        it = sb.pop_front();
        total++;
        if (grant_o !== it.g || ack_o !== it.a || status_o !== it.s) begin
          bad++;
          $display("FAIL %s grant=%b/%b ack=%b/%b status=%b/%b (actual/expected)",
                   it.tag, grant_o, it.g, ack_o, it.a, status_o, it.s);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    step("R1", 0, 4'b0000, 4'b0000, 0, 2'b00, 2'b00, 0, 3'b000, 0);
    // R2 no request -> no grant
    step("R2", 0, 4'b0000, 4'b1111, 0, 2'b00, 2'b00, 0, 3'b000, 1);
    // R3 fixed order
    step("R3", 1, 4'b1111, 4'b0000, 0, 2'b00, 2'b00, 0, 3'b000, 0);
    step("R3", 0, 4'b1010, 4'b0000, 0, 2'b00, 2'b00, 1, 3'b111, 0);
    step("R3", 0, 4'b1100, 4'b0000, 0, 2'b00, 2'b00, 0, 3'b000, 0);
    // R10 config write, R4 swapped order
    step("R10", 0, 4'b0000, 4'b0000, 1, 2'b10, 2'b00, 1, 3'b111, 0);
    step("R4", 1, 4'b0001, 4'b0000, 0, 2'b00, 2'b00, 0, 3'b000, 0);
    step("R4", 1, 4'b0010, 4'b0000, 0, 2'b00, 2'b00, 0, 3'b000, 0);
    // R5 round-robin from reset pointer
    step("R10", 0, 4'b0000, 4'b0000, 1, 2'b11, 2'b00, 1, 3'b111, 0);
    for (int n = 0; n < 7; n++)
      step("R5", 1, 4'b1111, 4'b0000, 0, 2'b00, 2'b00, 0, 3'b000, 0);
    step("R5", 1, 4'b0100, 4'b0000, 0, 2'b00, 2'b00, 0, 3'b000, 0);
    // R6 lockout
    step("R10", 0, 4'b0000, 4'b0000, 1, 2'b01, 2'b00, 1, 3'b111, 0);
    step("R6", 1, 4'b0000, 4'b0000, 0, 2'b00, 2'b00, 0, 3'b000, 0);
    step("R6", 0, 4'b1111, 4'b0000, 0, 2'b00, 2'b00, 0, 3'b000, 0);
    step("R6", 0, 4'b1101, 4'b0100, 0, 2'b00, 2'b00, 0, 3'b000, 0);
    step("R6", 1, 4'b1111, 4'b0000, 0, 2'b00, 2'b00, 0, 3'b000, 0);
    // R7 clear ends lockout one cycle later
    step("R7", 0, 4'b0001, 4'b0000, 0, 2'b00, 2'b00, 1, 3'b001, 0);
    step("R7", 0, 4'b0001, 4'b0000, 0, 2'b00, 2'b00, 0, 3'b000, 0);
    // R8 set wins over clear; clear of other flags
    step("R8", 1, 4'b0000, 4'b0000, 0, 2'b00, 2'b00, 1, 3'b001, 0);
    step("R8", 0, 4'b0000, 4'b0000, 0, 2'b00, 2'b00, 1, 3'b110, 0);
    step("R8", 0, 4'b0000, 4'b0000, 0, 2'b00, 2'b00, 1, 3'b001, 0);
    // R9 acknowledge styles
    step("R10", 0, 4'b0000, 4'b0000, 1, 2'b00, 2'b00, 0, 3'b000, 0);
    step("R9", 0, 4'b0100, 4'b0000, 0, 2'b00, 2'b00, 0, 3'b000, 1);
    step("R9", 0, 4'b1000, 4'b0000, 1, 2'b00, 2'b11, 0, 3'b000, 0);
    step("R9", 0, 4'b0000, 4'b0000, 0, 2'b00, 2'b00, 0, 3'b000, 1);
    step("R9", 0, 4'b0000, 4'b0000, 0, 2'b00, 2'b00, 0, 3'b000, 0);
    step("R9", 0, 4'b0100, 4'b0000, 0, 2'b00, 2'b00, 0, 3'b000, 1);
    step("R9", 0, 4'b0000, 4'b0000, 0, 2'b00, 2'b00, 0, 3'b000, 1);
    step("R2", 0, 4'b0000, 4'b0000, 0, 2'b00, 2'b00, 0, 3'b000, 0);
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule